// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

This block is a 4-bit twisted-ring counter that steps through eight states. On every clock edge the stored bits move one place toward the most significant end, and the lowest bit takes the inverse of the bit that leaves the top. The eight states are one code per step. Each pair of neighbouring codes differs in one bit, so the outputs can be decoded without glitches. The counter is suitable for phase sequencing, divide-by-eight timing and similar control work.

A plain twisted ring with four bits has eight further codes that form separate loops, and the counter never leaves those loops. This block adds a repair path. Any code whose top bit and bottom bit are both zero is replaced on the next edge by a parallel load of 0001. In the valid code 0000 the load gives the same value as a normal shift, so the repair never changes the legal sequence. Every other code returns to the legal sequence within a few edges.

Top module: `self_fix_johnson`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `q` becomes 0000 after that edge, whatever its earlier value.
- R2: After reset is released, `q` (written q[3] down to q[0]) takes 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000 on successive edges, and then repeats the same sequence.
- R3: When q[3] or q[0] is 1, the next q[0] is the inverse of the present q[3].
- R4: When q[3] or q[0] is 1, the next q[3:1] equals the present q[2:0].
- R5: When q[3] and q[0] are both 0, the next value of `q` is 0001.
- R6: From any of the eight codes listed in R2, including 0000, the next code is also one of those eight codes.
- R7: From any of the codes 0010, 0100, 0101, 0110, 1001, 1010, 1011 and 1101, `q` holds one of the R2 codes after at most 3 edges, and no more than 3 successive edges show codes outside the R2 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, clears the count |
| q | output | WIDTH (4) | Counter state, bit 0 is the entry end of the ring |

## Verification
The hard case to reach is an illegal code. Reset and the normal sequence never produce one, and the block has no input that could place one. The bench holds reset for one edge, because all sequence checks are turned off while reset is low. During that gap it overwrites the state register with each of the eight illegal codes and then releases reset. It then follows the repair path edge by edge against a rule model and confirms that a legal code appears by the third edge.

// File: rtl/jc_pkg.sv
`timescale 1ns/1ps
// Package jc_pkg
// Purpose : shared types and defaults for the self-correcting twisted ring.
// Assumes : nothing; contains declarations only.
package jc_pkg;

    // Default ring width; the recovery bound in the top is stated for it.
    localparam int JC_DEFAULT_W = 4;

    // Action chosen for the next edge.
    typedef enum logic {
        JC_SHIFT = 1'b0,
        JC_LOAD  = 1'b1
    } jc_action_e;

endpackage

// File: rtl/jc_fix_detect.sv
`timescale 1ns/1ps
// Module jc_fix_detect
// Purpose : spots the codes that must be repaired by a parallel load,
//           i.e. both end bits of the ring equal to zero.
// Assumes : WIDTH >= 3; purely combinational.
module jc_fix_detect
    import jc_pkg::*;
#(
    parameter int WIDTH = JC_DEFAULT_W
) (
    input  logic [WIDTH-1:0] cur_q,
    output jc_action_e       action
);

    // Choose load when both end bits are clear, otherwise shift.
    always_comb begin
        if (!cur_q[WIDTH-1] && !cur_q[0]) begin
            action = JC_LOAD;
        end else begin
            action = JC_SHIFT;
        end
    end

endmodule

// File: rtl/jc_next_state.sv
`timescale 1ns/1ps
// Module jc_next_state
// Purpose : forms the next ring value, either the inverted-feedback shift
//           toward the top bit or the repair seed 0...01.
// Assumes : WIDTH >= 3; purely combinational.
module jc_next_state
    import jc_pkg::*;
#(
    parameter int WIDTH = JC_DEFAULT_W
) (
    input  logic [WIDTH-1:0] cur_q,
    input  jc_action_e       action,
    output logic [WIDTH-1:0] nxt_q
);

    localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

    logic [WIDTH-1:0] shifted;

    // Entry bit takes the inverse of the bit leaving the top.
    assign shifted[0] = ~cur_q[WIDTH-1];

    // Every other bit takes its lower neighbour.
    for (genvar gi = 1; gi < WIDTH; gi++) begin : g_shift
        assign shifted[gi] = cur_q[gi-1];
    end

    // Select between repair seed and plain shift.
    always_comb begin
        if (action == JC_LOAD) begin
            nxt_q = SEED;
        end else begin
            nxt_q = shifted;
        end
    end

endmodule

// File: rtl/jc_state_reg.sv
`timescale 1ns/1ps
// Module jc_state_reg
// Purpose : holds the ring state; clears to all zeros on reset.
// Assumes : rst_n is synchronous and active low.
module jc_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] nxt_q,
    output logic [WIDTH-1:0] cur_q
);

    logic [WIDTH-1:0] state_q;

    // Capture the next ring value, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= nxt_q;
        end
    end

    assign cur_q = state_q;

endmodule

// File: rtl/self_fix_johnson.sv
`timescale 1ns/1ps
// Module self_fix_johnson
// Purpose : top of the self-correcting twisted-ring counter. Wires the
//           repair detector, next-state former and state register, and
//           carries the sequence assertions.
// Assumes : synchronous active-low reset; the recovery bound of WIDTH-1
//           edges is stated for the default width of 4.
module self_fix_johnson
    import jc_pkg::*;
#(
    parameter int WIDTH = JC_DEFAULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] q
);

    localparam int RECOVER_MAX = WIDTH - 1;
    localparam int RUN_W       = $clog2(WIDTH + 2);

    jc_action_e       action;
    logic [WIDTH-1:0] nxt_q;
    logic [WIDTH-1:0] cur_q;

    jc_fix_detect #(.WIDTH(WIDTH)) u_detect (
        .cur_q  (cur_q),
        .action (action)
    );

    jc_next_state #(.WIDTH(WIDTH)) u_next (
        .cur_q  (cur_q),
        .action (action),
        .nxt_q  (nxt_q)
    );

    jc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_q  (nxt_q),
        .cur_q  (cur_q)
    );

    assign q = cur_q;

    // ---------------- assertions ----------------

    // A legal code has at most one boundary between neighbouring bits.
    logic ring_ok;
    assign ring_ok = ($countones(q[WIDTH-1:1] ^ q[WIDTH-2:0]) <= 1);

    // Count successive edges that show an illegal code (checker only).
    logic [RUN_W-1:0] bad_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_run_q <= '0;
        end else if (ring_ok) begin
            bad_run_q <= '0;
        end else if (bad_run_q != '1) begin
            bad_run_q <= bad_run_q + 1'b1;
        end
    end

    // R3: inverted feedback into the entry bit on a shift.
    p_invert_feed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q[WIDTH-1] || q[0]) |=> (q[0] == !$past(q[WIDTH-1])));

    // R4: remaining bits move one place toward the top.
    p_shift_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q[WIDTH-1] || q[0]) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

    // R5: both end bits clear forces the seed on the next edge.
    p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q[WIDTH-1] && !q[0]) |=> (q == WIDTH'(1)));

    // R6: the legal set is closed under one step.
    p_closed_ring_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ok |=> ring_ok);

    // R7: an illegal code never persists past the recovery bound.
    p_recover_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_run_q <= RUN_W'(RECOVER_MAX));

endmodule

// File: tb/self_fix_johnson_tb.sv
`timescale 1ns/1ps
// Bench for self_fix_johnson: driver pushes expected codes into a
// scoreboard queue, a monitor pops and compares them each falling edge.
module self_fix_johnson_tb;

    localparam int W = 4;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] q;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    logic [W-1:0] legal_seq [8] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111,
                                    4'b1111, 4'b1110, 4'b1100, 4'b1000};
    logic [W-1:0] bad_codes [8] = '{4'b0010, 4'b0100, 4'b0101, 4'b0110,
                                    4'b1001, 4'b1010, 4'b1011, 4'b1101};

    self_fix_johnson #(.WIDTH(W)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (q)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Next code from the stated rules (R3, R4, R5).
    function automatic logic [W-1:0] rule_next(input logic [W-1:0] s);
        if (!s[W-1] && !s[0]) return 4'b0001;
        return {s[W-2:0], ~s[W-1]};
    endfunction

    function automatic bit is_legal(input logic [W-1:0] s);
        for (int i = 0; i < 8; i++) if (legal_seq[i] == s) return 1'b1;
        return 1'b0;
    endfunction

    task automatic push(input logic [W-1:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Wait one edge, then queue the value expected after it.
    task automatic step(input logic [W-1:0] exp, input string tag);
        @(posedge clk);
        #1;
        push(exp, tag);
    endtask

    // Monitor: compare the oldest expectation on the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (q !== it.exp) begin
                errors++;
                $display("FAIL %s: q=%b expected %b", it.tag, q, it.exp);
            end
        end
    end

    // Place an illegal code via a reset gap, then follow the repair.
    task automatic inject(input logic [W-1:0] val);
        logic [W-1:0] cur;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        force u_dut.u_reg.state_q = val;
        release u_dut.u_reg.state_q;
        rst_n = 1'b1;
        push(val, "R7 injected code");
        cur = val;
        for (int k = 0; k < 3; k++) begin
            logic [W-1:0] nxt;
            nxt = rule_next(cur);
            if (!cur[W-1] && !cur[0]) step(nxt, "R5 repair load");
            else                      step(nxt, "R3 R4 shift");
            cur = nxt;
        end
        checks++;
        if (!is_legal(q)) begin
            errors++;
            $display("FAIL R7: from %b q=%b expected a legal code after 3 edges",
                     val, q);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        step(4'b0000, "R1 reset state");
        step(4'b0000, "R1 reset held");
        rst_n = 1'b1;
        // R2 R6: two full turns of the legal sequence.
        for (int i = 1; i <= 16; i++) step(legal_seq[i % 8], "R2 R6 sequence");
        for (int i = 1; i <= 3; i++)  step(legal_seq[i], "R2 sequence");
        // R1: reset in the middle of the run, from 0111.
        rst_n = 1'b0;
        step(4'b0000, "R1 mid-run reset");
        rst_n = 1'b1;
        step(4'b0001, "R5 load from 0000");
        // R7: every illegal code.
        for (int i = 0; i < 8; i++) inject(bad_codes[i]);
        step(rule_next(q), "R6 after recovery");
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule